// File: doc/BRIEF.md
# Overlapping register window file

This block is a register file for a processor whose procedures each receive a private bank of registers. The windowed storage forms a ring of windows. Each window owns eight local and eight incoming-argument registers. Its eight outgoing-argument registers are, physically, the incoming-argument registers of the next window in the ring. A value a caller places in its outgoing registers therefore appears in the callee's incoming registers with no copy. A separate bank of eight global registers is seen identically from every window.

The datapath reads two registers and writes one per cycle, each addressed by a 5-bit logical register number. A call strobe moves the current window pointer forward by one and a return strobe moves it back. A second pointer marks the one ring slot kept empty as a reserve.

- Overflow: a call whose target window is the reserved slot raises a sticky overflow flag. The block then copies the oldest resident window (its locals and ins) to memory, one word per accepted transfer.
- Underflow: a return whose target is the reserved slot raises a sticky underflow flag. The block then reloads that window from memory.

The trap software acknowledges each flag with a clear strobe and reissues the call or return.

Top module: `regwin_file`

## Requirements
- R1: Logical register numbers map as follows. Bits [4:3] select the group: 0 for globals, 1 for outs, 2 for locals, 3 for ins. Bits [2:0] give the offset within the group. For current window w (8 windows, 16 physical registers each), a local is physical register 16*w+offset and an in is 16*w+8+offset. An out is physical register 16*((w+1) mod 8)+8+offset, which is the in of the next window.
- R2: Logical register 0 always reads as zero on both read ports, and a write to it has no effect.
- R3: Global registers (logical 1 to 7) hold their contents and read the same value from every window.
- R4: An accepted call raises the current window pointer by one modulo 8, and an accepted return lowers it by one modulo 8. Reads and a write in the same cycle as the strobe use the old mapping. The new mapping applies from the next cycle.
- R5: After reset the current window pointer is 0, the reserve pointer is 7, both trap flags are clear, the block is idle and no memory request is raised.
- R6: A call while idle, with the current pointer plus one equal to the reserve pointer, sets the overflow flag and leaves the current pointer unchanged. The block then spills window (reserve+1) mod 8 as 16 write transfers. Slots run 0 to 15 in order (locals, then ins), and the address is 16*window+slot. Afterwards the reserve pointer rises by one modulo 8.
- R7: A return while idle, with the current pointer minus one equal to the reserve pointer, sets the underflow flag and leaves the current pointer unchanged. The block then fills the reserved window from 16 read transfers. Slots run 0 to 15, and the address is 16*window+slot. Afterwards the reserve pointer falls by one modulo 8.
- R8: A memory transfer completes only in a cycle where both the request valid and ready are high. While ready is low the request, address and write flag hold steady. Exactly 16 transfers take place per spill or fill, whatever the stall pattern.
- R9: The overflow and underflow flags stay set until a cycle with the clear strobe high, and the flags clear at the end of that cycle.
- R10: While a spill or fill is in progress, call, return and register writes are ignored. A call and a return in the same cycle are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| trap_clr_i | input | 1 | Clears both trap flags |
| rs1_i | input | 5 | Logical register, read port 1 |
| rs2_i | input | 5 | Logical register, read port 2 |
| rd1_o | output | DATA_W | Read data, port 1 |
| rd2_o | output | DATA_W | Read data, port 2 |
| we_i | input | 1 | Write enable |
| wa_i | input | 5 | Logical register to write |
| wd_i | input | DATA_W | Write data |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Reserve (saved) window pointer |
| ovf_trap_o | output | 1 | Sticky overflow flag |
| unf_trap_o | output | 1 | Sticky underflow flag |
| busy_o | output | 1 | Spill or fill in progress |
| mem_valid_o | output | 1 | Memory transfer request |
| mem_write_o | output | 1 | 1 for spill (write), 0 for fill (read) |
| mem_addr_o | output | 7 | Word address, 16*window+slot |
| mem_wdata_o | output | DATA_W | Spill data |
| mem_ready_i | input | 1 | Memory accepts the transfer |
| mem_rdata_i | input | DATA_W | Fill data, valid while ready is high |

## Verification
Three kinds of internal fault show up at the ports.

- A wrong current window pointer shifts every windowed read by sixteen registers. The first read after the faulty call or return then returns another procedure's value. Sweeping all 31 nonzero registers in every window catches this in that same cycle.
- A wrong reserve pointer makes a trap fire one call early or late. It can also spill a window at the wrong address, which is visible in the first transfer's address. Otherwise it shows on the next reload, which returns foreign data.
- A miscounted transfer sequence leaves a slot unsaved or unrestored. That slot reads back incorrectly once the window is visited again after a fill whose memory contents were deliberately changed.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // Register group codes carried in the two upper bits of a logical number
  localparam logic [1:0] GRP_GLOBAL = 2'd0;
  localparam logic [1:0] GRP_OUT    = 2'd1;
  localparam logic [1:0] GRP_LOCAL  = 2'd2;
  localparam logic [1:0] GRP_IN     = 2'd3;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SPILL = 2'd1,
    ENG_FILL  = 2'd2
  } eng_state_e;

endpackage

// File: rtl/regwin_map.sv
module regwin_map #(
  parameter int WIN_BITS = 3,
  parameter int GRP_BITS = 3,
  localparam int LW = GRP_BITS + 2,
  localparam int PW = WIN_BITS + GRP_BITS + 1
) (
  input  logic [WIN_BITS-1:0] cwp,
  input  logic [LW-1:0]       lreg,
  output logic                is_glob,
  output logic [GRP_BITS-1:0] gidx,
  output logic [PW-1:0]       pidx
);
  import regwin_pkg::*;

  logic [1:0]          grp;
  logic [GRP_BITS-1:0] off;
  logic [WIN_BITS-1:0] nxt_win;

  assign grp     = lreg[LW-1 -: 2];
  assign off     = lreg[GRP_BITS-1:0];
  assign nxt_win = cwp + WIN_BITS'(1);
  assign gidx    = off;
  assign is_glob = (grp == GRP_GLOBAL);

  always_comb begin
    unique case (grp)
      GRP_OUT:   pidx = {nxt_win, 1'b1, off};
      GRP_LOCAL: pidx = {cwp, 1'b0, off};
      GRP_IN:    pidx = {cwp, 1'b1, off};
      default:   pidx = '0;
    endcase
  end

endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
  parameter int DATA_W   = 32,
  parameter int GRP_BITS = 3,
  parameter int PW       = 7,
  localparam int NG = 1 << GRP_BITS,
  localparam int NP = 1 << PW
) (
  input  logic                     clk,
  input  logic [1:0]               rd_glob,
  input  logic [1:0][GRP_BITS-1:0] rd_gidx,
  input  logic [1:0][PW-1:0]       rd_pidx,
  output logic [1:0][DATA_W-1:0]   rd_data,
  input  logic                     wr_en,
  input  logic                     wr_glob,
  input  logic [GRP_BITS-1:0]      wr_gidx,
  input  logic [PW-1:0]            wr_pidx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [PW-1:0]            eng_pidx,
  input  logic                     eng_we,
  input  logic [DATA_W-1:0]        eng_wdata,
  output logic [DATA_W-1:0]        eng_rdata
);

  logic [DATA_W-1:0] glob_q [NG];
  logic [DATA_W-1:0] win_q  [NP];

  logic glob_we;
  logic win_we;

  assign glob_we = wr_en && wr_glob && (wr_gidx != '0);
  assign win_we  = wr_en && !wr_glob;

  always_ff @(posedge clk) begin
    if (glob_we) begin
      glob_q[wr_gidx] <= wr_data;
    end
  end

  // The refill engine has priority; the top blocks datapath writes while busy
  always_ff @(posedge clk) begin
    if (eng_we) begin
      win_q[eng_pidx] <= eng_wdata;
    end else if (win_we) begin
      win_q[wr_pidx] <= wr_data;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      if (rd_glob[p]) begin
        rd_data[p] = (rd_gidx[p] == '0) ? '0 : glob_q[rd_gidx[p]];
      end else begin
        rd_data[p] = win_q[rd_pidx[p]];
      end
    end
  end

  assign eng_rdata = win_q[eng_pidx];

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
  parameter int WIN_BITS = 3,
  parameter int GRP_BITS = 3,
  localparam int SLOT_BITS = GRP_BITS + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 call,
  input  logic                 ret,
  input  logic                 trap_clr,
  input  logic                 mem_ready,
  output logic [WIN_BITS-1:0]  cwp,
  output logic [WIN_BITS-1:0]  swp,
  output logic                 ovf,
  output logic                 unf,
  output logic                 busy,
  output logic                 mem_valid,
  output logic                 mem_write,
  output logic [WIN_BITS-1:0]  eng_win,
  output logic [SLOT_BITS-1:0] eng_slot,
  output logic                 eng_we
);
  import regwin_pkg::*;

  eng_state_e          state_q, state_d;
  logic [SLOT_BITS-1:0] cnt_q, cnt_d;
  logic [WIN_BITS-1:0]  cwp_q, cwp_d;
  logic [WIN_BITS-1:0]  swp_q, swp_d;
  logic                 ovf_q, ovf_d;
  logic                 unf_q, unf_d;

  logic [WIN_BITS-1:0] cwp_up, cwp_dn, swp_up, swp_dn;
  logic                step, last;
  logic                ptr_en, flag_en, eng_en;

  assign cwp_up = cwp_q + WIN_BITS'(1);
  assign cwp_dn = cwp_q - WIN_BITS'(1);
  assign swp_up = swp_q + WIN_BITS'(1);
  assign swp_dn = swp_q - WIN_BITS'(1);
  assign step   = (state_q != ENG_IDLE) && mem_ready;
  assign last   = (cnt_q == '1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cwp_d   = cwp_q;
    swp_d   = swp_q;
    ovf_d   = ovf_q && !trap_clr;
    unf_d   = unf_q && !trap_clr;
    unique case (state_q)
      ENG_IDLE: begin
        if (call && !ret) begin
          if (cwp_up == swp_q) begin
            ovf_d   = 1'b1;
            state_d = ENG_SPILL;
            cnt_d   = '0;
          end else begin
            cwp_d = cwp_up;
          end
        end else if (ret && !call) begin
          if (cwp_dn == swp_q) begin
            unf_d   = 1'b1;
            state_d = ENG_FILL;
            cnt_d   = '0;
          end else begin
            cwp_d = cwp_dn;
          end
        end
      end
      ENG_SPILL: begin
        if (step) begin
          cnt_d = cnt_q + SLOT_BITS'(1);
          if (last) begin
            state_d = ENG_IDLE;
            swp_d   = swp_up;
          end
        end
      end
      ENG_FILL: begin
        if (step) begin
          cnt_d = cnt_q + SLOT_BITS'(1);
          if (last) begin
            state_d = ENG_IDLE;
            swp_d   = swp_dn;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  assign ptr_en  = (cwp_d != cwp_q) || (swp_d != swp_q);
  assign flag_en = (ovf_d != ovf_q) || (unf_d != unf_q);
  assign eng_en  = (state_d != state_q) || (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      swp_q <= '1;
    end else if (ptr_en) begin
      cwp_q <= cwp_d;
      swp_q <= swp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (flag_en) begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
    end else if (eng_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cwp       = cwp_q;
  assign swp       = swp_q;
  assign ovf       = ovf_q;
  assign unf       = unf_q;
  assign busy      = (state_q != ENG_IDLE);
  assign mem_valid = busy;
  assign mem_write = (state_q == ENG_SPILL);
  assign eng_win   = (state_q == ENG_SPILL) ? swp_up : swp_q;
  assign eng_slot  = cnt_q;
  assign eng_we    = (state_q == ENG_FILL) && mem_ready;

endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 3,
  parameter int GRP_BITS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          call_i,
  input  logic                          ret_i,
  input  logic                          trap_clr_i,
  input  logic [GRP_BITS+1:0]           rs1_i,
  input  logic [GRP_BITS+1:0]           rs2_i,
  output logic [DATA_W-1:0]             rd1_o,
  output logic [DATA_W-1:0]             rd2_o,
  input  logic                          we_i,
  input  logic [GRP_BITS+1:0]           wa_i,
  input  logic [DATA_W-1:0]             wd_i,
  output logic [WIN_BITS-1:0]           cwp_o,
  output logic [WIN_BITS-1:0]           swp_o,
  output logic                          ovf_trap_o,
  output logic                          unf_trap_o,
  output logic                          busy_o,
  output logic                          mem_valid_o,
  output logic                          mem_write_o,
  output logic [WIN_BITS+GRP_BITS:0]    mem_addr_o,
  output logic [DATA_W-1:0]             mem_wdata_o,
  input  logic                          mem_ready_i,
  input  logic [DATA_W-1:0]             mem_rdata_i
);

  localparam int LW        = GRP_BITS + 2;
  localparam int PW        = WIN_BITS + GRP_BITS + 1;
  localparam int SLOT_BITS = GRP_BITS + 1;
  localparam int NPORT     = 3;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [WIN_BITS-1:0]  cwp;
  logic [WIN_BITS-1:0]  eng_win;
  logic [SLOT_BITS-1:0] eng_slot;
  logic                 eng_we;
  logic                 busy;
  logic [PW-1:0]        eng_pidx;
  logic [DATA_W-1:0]    eng_rdata;

  regwin_ctrl #(
    .WIN_BITS (WIN_BITS),
    .GRP_BITS (GRP_BITS)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .call      (call_i),
    .ret       (ret_i),
    .trap_clr  (trap_clr_i),
    .mem_ready (mem_ready_i),
    .cwp       (cwp),
    .swp       (swp_o),
    .ovf       (ovf_trap_o),
    .unf       (unf_trap_o),
    .busy      (busy),
    .mem_valid (mem_valid_o),
    .mem_write (mem_write_o),
    .eng_win   (eng_win),
    .eng_slot  (eng_slot),
    .eng_we    (eng_we)
  );

  // Port 0 and 1 are the read ports, port 2 the write port
  logic [NPORT-1:0][LW-1:0]       lreg;
  logic [NPORT-1:0]               m_glob;
  logic [NPORT-1:0][GRP_BITS-1:0] m_gidx;
  logic [NPORT-1:0][PW-1:0]       m_pidx;

  assign lreg[0] = rs1_i;
  assign lreg[1] = rs2_i;
  assign lreg[2] = wa_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    regwin_map #(
      .WIN_BITS (WIN_BITS),
      .GRP_BITS (GRP_BITS)
    ) i_map (
      .cwp     (cwp),
      .lreg    (lreg[p]),
      .is_glob (m_glob[p]),
      .gidx    (m_gidx[p]),
      .pidx    (m_pidx[p])
    );
  end

  logic [1:0][DATA_W-1:0] rd_data;

  assign eng_pidx = {eng_win, eng_slot};

  regwin_store #(
    .DATA_W   (DATA_W),
    .GRP_BITS (GRP_BITS),
    .PW       (PW)
  ) i_store (
    .clk       (clk),
    .rd_glob   (m_glob[1:0]),
    .rd_gidx   (m_gidx[1:0]),
    .rd_pidx   (m_pidx[1:0]),
    .rd_data   (rd_data),
    .wr_en     (we_i && !busy),
    .wr_glob   (m_glob[2]),
    .wr_gidx   (m_gidx[2]),
    .wr_pidx   (m_pidx[2]),
    .wr_data   (wd_i),
    .eng_pidx  (eng_pidx),
    .eng_we    (eng_we),
    .eng_wdata (mem_rdata_i),
    .eng_rdata (eng_rdata)
  );

  assign rd1_o       = rd_data[0];
  assign rd2_o       = rd_data[1];
  assign cwp_o       = cwp;
  assign busy_o      = busy;
  assign mem_addr_o  = eng_pidx;
  assign mem_wdata_o = eng_rdata;

endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 3,
  parameter int GRP_BITS = 3,
  localparam int PW = WIN_BITS + GRP_BITS + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                call_i,
  input logic                ret_i,
  input logic                trap_clr_i,
  input logic [GRP_BITS+1:0] rs1_i,
  input logic [DATA_W-1:0]   rd1_o,
  input logic [WIN_BITS-1:0] cwp_o,
  input logic [WIN_BITS-1:0] swp_o,
  input logic                ovf_trap_o,
  input logic                unf_trap_o,
  input logic                busy_o,
  input logic                mem_valid_o,
  input logic                mem_write_o,
  input logic [PW-1:0]       mem_addr_o,
  input logic                mem_ready_i
);

  logic [WIN_BITS-1:0] cwp_up, cwp_dn, swp_up;
  logic                do_call, do_ret;

  assign cwp_up  = cwp_o + WIN_BITS'(1);
  assign cwp_dn  = cwp_o - WIN_BITS'(1);
  assign swp_up  = swp_o + WIN_BITS'(1);
  assign do_call = !busy_o && call_i && !ret_i;
  assign do_ret  = !busy_o && ret_i && !call_i;

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rs1_i == '0) |-> (rd1_o == '0)); // R2

  AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (do_call && cwp_up != swp_o) |=> (cwp_o == $past(cwp_up))); // R4

  AST_RET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ret && cwp_dn != swp_o) |=> (cwp_o == $past(cwp_dn))); // R4

  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (do_call && cwp_up == swp_o) |=> (ovf_trap_o && busy_o && mem_write_o && $stable(cwp_o))); // R6

  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ret && cwp_dn == swp_o) |=> (unf_trap_o && busy_o && !mem_write_o && $stable(cwp_o))); // R7

  AST_SPILL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && mem_write_o) |-> (mem_addr_o[PW-1 -: WIN_BITS] == swp_up)); // R6

  AST_FILL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_write_o) |-> (mem_addr_o[PW-1 -: WIN_BITS] == swp_o)); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_write_o))); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_trap_o && !trap_clr_i) |=> ovf_trap_o); // R9

  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_trap_o && !trap_clr_i) |=> unf_trap_o); // R9

  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(cwp_o)); // R10

  AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && call_i && ret_i) |=> ($stable(cwp_o) && !busy_o)); // R10

endmodule

bind regwin_file regwin_file_chk #(
  .DATA_W   (DATA_W),
  .WIN_BITS (WIN_BITS),
  .GRP_BITS (GRP_BITS)
) i_regwin_file_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .trap_clr_i  (trap_clr_i),
  .rs1_i       (rs1_i),
  .rd1_o       (rd1_o),
  .cwp_o       (cwp_o),
  .swp_o       (swp_o),
  .ovf_trap_o  (ovf_trap_o),
  .unf_trap_o  (unf_trap_o),
  .busy_o      (busy_o),
  .mem_valid_o (mem_valid_o),
  .mem_write_o (mem_write_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/test_regwin_file.sv
`timescale 1ns/1ps
module test_regwin_file;

  logic        clk;
  logic        rst_n;
  logic        call_i, ret_i, trap_clr_i;
  logic [4:0]  rs1_i, rs2_i, wa_i;
  logic [31:0] rd1_o, rd2_o, wd_i;
  logic        we_i;
  logic [2:0]  cwp_o, swp_o;
  logic        ovf_trap_o, unf_trap_o, busy_o;
  logic        mem_valid_o, mem_write_o, mem_ready_i;
  logic [6:0]  mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;

  regwin_file i_regwin_file (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .trap_clr_i(trap_clr_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .rd1_o(rd1_o), .rd2_o(rd2_o),
    .we_i(we_i), .wa_i(wa_i), .wd_i(wd_i),
    .cwp_o(cwp_o), .swp_o(swp_o), .ovf_trap_o(ovf_trap_o), .unf_trap_o(unf_trap_o),
    .busy_o(busy_o), .mem_valid_o(mem_valid_o), .mem_write_o(mem_write_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int          checks;
  int          errors;
  logic [31:0] stamp;
  logic [31:0] phys_m [128];
  logic [31:0] glob_m [8];
  logic [31:0] mem_b  [128];
  logic [6:0]  xfer_addr [32];
  int          xfer_n;
  int          rcnt;
  int          cwp_m;
  int          swp_m;

  assign mem_rdata_i = mem_b[mem_addr_o];

  // Memory side: ready high two cycles of three; record completed transfers
  always @(negedge clk) begin
    rcnt = rcnt + 1;
    mem_ready_i = (rcnt % 3) != 0;
    if (mem_valid_o && mem_ready_i) begin
      if (xfer_n < 32) xfer_addr[xfer_n] = mem_addr_o;
      xfer_n = xfer_n + 1;
      if (mem_write_o) mem_b[mem_addr_o] = mem_wdata_o;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic int phys_of(input int cw, input int r);
    int off;
    off = r % 8;
    case (r / 8)
      1:       return ((cw + 1) % 8) * 16 + 8 + off;
      2:       return cw * 16 + off;
      default: return cw * 16 + 8 + off;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input int cw, input int r);
    if (r == 0) return 32'h0;
    if (r < 8) return glob_m[r];
    return phys_m[phys_of(cw, r)];
  endfunction

  function automatic logic [31:0] next_stamp();
    stamp = stamp * 32'd1103515245 + 32'd12345;
    return stamp;
  endfunction

  task automatic wr(input int r, input logic [31:0] v);
    we_i = 1'b1; wa_i = 5'(r); wd_i = v;
    tick();
    we_i = 1'b0;
    if (r >= 8) phys_m[phys_of(cwp_m, r)] = v;
    else if (r != 0) glob_m[r] = v;
  endtask

  task automatic check_window(input string req);
    for (int r = 1; r < 32; r++) begin
      rs1_i = 5'(r);
      rs2_i = 5'((r + 9) % 32);
      #0.2;
      chk(req, rd1_o, exp_rd(cwp_m, r));
      chk(req, rd2_o, exp_rd(cwp_m, (r + 9) % 32));
    end
  endtask

  task automatic fill_window();
    for (int r = 8; r < 32; r++) wr(r, next_stamp());
  endtask

  task automatic pulse_call();
    call_i = 1'b1; tick(); call_i = 1'b0;
  endtask

  task automatic pulse_ret();
    ret_i = 1'b1; tick(); ret_i = 1'b0;
  endtask

  task automatic pulse_clr();
    trap_clr_i = 1'b1; tick(); trap_clr_i = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy_o && cyc < 500) begin
      tick();
      cyc++;
    end
  endtask

  task automatic check_xfers(input string req, input int base);
    chk({req, " transfer count"}, 32'(xfer_n), 32'd16);
    for (int k = 0; k < 16; k++) chk({req, " address order"}, 32'(xfer_addr[k]), 32'(base + k));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] keep;
    checks = 0; errors = 0; stamp = 32'h1234_5678; rcnt = 0; xfer_n = 0;
    mem_ready_i = 1'b0;
    for (int k = 0; k < 128; k++) mem_b[k] = 32'h0;
    call_i = 0; ret_i = 0; trap_clr_i = 0; we_i = 0;
    rs1_i = 0; rs2_i = 0; wa_i = 0; wd_i = 0;
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R5: reset state
    chk("R5 cwp", 32'(cwp_o), 32'd0);
    chk("R5 swp", 32'(swp_o), 32'd7);
    chk("R5 flags", {30'd0, ovf_trap_o, unf_trap_o}, 32'd0);
    chk("R5 idle", {30'd0, busy_o, mem_valid_o}, 32'd0);
    cwp_m = 0; swp_m = 7;

    // R2 / R3: globals and register zero
    for (int r = 0; r < 8; r++) wr(r, next_stamp());
    for (int r = 0; r < 8; r++) begin
      rs1_i = 5'(r); rs2_i = 5'(r); #0.2;
      chk("R2 R3 global read p1", rd1_o, exp_rd(0, r));
      chk("R2 R3 global read p2", rd2_o, exp_rd(0, r));
    end

    // R1 / R3 / R4: walk windows 0..6, writing and sweeping each one
    fill_window();
    check_window("R1 window 0");
    for (int k = 1; k <= 6; k++) begin
      if (k == 3) begin
        // R4: same-cycle read and write use the old mapping
        keep = next_stamp();
        rs1_i = 5'd16; we_i = 1'b1; wa_i = 5'd17; wd_i = keep; call_i = 1'b1;
        #0.2;
        chk("R4 same-cycle read old window", rd1_o, exp_rd(cwp_m, 16));
        tick();
        call_i = 1'b0; we_i = 1'b0;
        phys_m[phys_of(cwp_m, 17)] = keep;
      end else begin
        pulse_call();
      end
      cwp_m = k;
      chk("R4 call advances cwp", 32'(cwp_o), 32'(k));
      check_window("R1 R3 after call");
      fill_window();
    end

    // R10: call and return together ignored
    call_i = 1'b1; ret_i = 1'b1; tick(); call_i = 1'b0; ret_i = 1'b0;
    chk("R10 call+ret ignored", 32'(cwp_o), 32'd6);

    // R6: first overflow spills window 0
    xfer_n = 0;
    pulse_call();
    chk("R6 overflow flag", {31'd0, ovf_trap_o}, 32'd1);
    chk("R6 busy", {31'd0, busy_o}, 32'd1);
    chk("R6 cwp held", 32'(cwp_o), 32'd6);
    // R10: strobes and writes during the spill are ignored
    call_i = 1'b1; we_i = 1'b1; wa_i = 5'd16; wd_i = 32'hDEAD_BEEF;
    tick();
    call_i = 1'b0; we_i = 1'b0;
    wait_idle(cyc);
    chk("R8 stalls stretched spill", {31'd0, (cyc + 1) > 16}, 32'd1);
    check_xfers("R6 R8 spill", 0);
    for (int k = 0; k < 16; k++) chk("R6 spilled data", mem_b[k], phys_m[k]);
    chk("R6 swp advanced", 32'(swp_o), 32'd0);
    chk("R10 cwp unchanged by busy call", 32'(cwp_o), 32'd6);
    chk("R9 overflow sticky", {31'd0, ovf_trap_o}, 32'd1);
    rs1_i = 5'd16; #0.2;
    chk("R10 write during busy ignored", rd1_o, exp_rd(6, 16));
    pulse_clr();
    chk("R9 overflow cleared", {31'd0, ovf_trap_o}, 32'd0);
    swp_m = 0;

    // Reissued call now succeeds; window 7 outs alias window 0 ins
    pulse_call();
    cwp_m = 7;
    chk("R4 call into window 7", 32'(cwp_o), 32'd7);
    check_window("R1 window 7 wraps");
    fill_window();

    // R6: second overflow spills window 1
    xfer_n = 0;
    pulse_call();
    chk("R6 second overflow", {31'd0, ovf_trap_o}, 32'd1);
    wait_idle(cyc);
    check_xfers("R6 second spill", 16);
    for (int k = 16; k < 32; k++) chk("R6 spilled data w1", mem_b[k], phys_m[k]);
    chk("R6 swp to 1", 32'(swp_o), 32'd1);
    pulse_clr();
    swp_m = 1;

    // Returns from 7 down to 2
    for (int k = 6; k >= 2; k--) begin
      pulse_ret();
      cwp_m = k;
      chk("R4 return retreats cwp", 32'(cwp_o), 32'(k));
      check_window("R1 after return");
    end

    // R7: underflow refills window 1 from altered memory
    for (int k = 16; k < 32; k++) begin
      mem_b[k] = next_stamp();
      phys_m[k] = mem_b[k];
    end
    xfer_n = 0;
    pulse_ret();
    chk("R7 underflow flag", {31'd0, unf_trap_o}, 32'd1);
    chk("R7 cwp held", 32'(cwp_o), 32'd2);
    wait_idle(cyc);
    check_xfers("R7 R8 fill", 16);
    chk("R7 swp retreats", 32'(swp_o), 32'd0);
    chk("R9 underflow sticky", {31'd0, unf_trap_o}, 32'd1);
    check_window("R7 window 2 intact");
    pulse_clr();
    chk("R9 underflow cleared", {31'd0, unf_trap_o}, 32'd0);
    pulse_ret();
    cwp_m = 1;
    check_window("R7 refilled window 1");

    // R7: second underflow refills window 0, swp wraps to 7
    for (int k = 0; k < 16; k++) begin
      mem_b[k] = next_stamp();
      phys_m[k] = mem_b[k];
    end
    xfer_n = 0;
    pulse_ret();
    chk("R7 second underflow", {31'd0, unf_trap_o}, 32'd1);
    wait_idle(cyc);
    check_xfers("R7 second fill", 0);
    chk("R7 swp wraps", 32'(swp_o), 32'd7);
    pulse_clr();
    pulse_ret();
    cwp_m = 0;
    chk("R4 back in window 0", 32'(cwp_o), 32'd0);
    check_window("R7 refilled window 0");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule